// File: doc/BRIEF.md
# Absolute-Average Automatic Gain Control

This block closes a digital gain loop around a microphone amplifier. Each time the ADC presents a new signed sample together with a one-cycle strobe, the block updates a level estimate. The estimate is a first-order recursive average of the sample magnitude, not a peak hold. The block then decides whether the amplifier gain code should move by one 0.5 dB step. Loud material pulls the code down under the attack setting. Quiet material above a programmable floor lets it climb under the decay setting. Material below that floor leaves the code untouched, so background hiss is not amplified.

Eight coded target levels cover roughly -5.5 dB to -24 dB of full scale. A programmable ceiling bounds the code. With the loop switched off, a fixed gain value is passed straight through. The block only produces the requested code and a pulse marking each sample's update. Smoothing the applied analog gain belongs to the amplifier side.

Top module: `agc_absavg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the level estimate, gain code and step counter clear to zero and `gain_valid` goes low. With `agc_en` high, `gain_code` reads 0 after reset.
- R2: `gain_valid` is high for exactly the one cycle that follows each clock edge at which `sample_stb` was high. In loop mode the gain code changes only at such edges, except for the ceiling clamp in R10.
- R3: With `agc_en` low, `gain_code` equals `fixed_gain` combinationally. The internal code is loaded from `fixed_gain` every cycle and the step counter is cleared, so a later enable starts from the fixed value.
- R4: On each strobe the magnitude m = |sample| is formed, with the most negative input saturating to 2^(SAMPLE_W-1)-1. The estimate L then becomes L + ((m - L) >>> s), using an arithmetic shift. s is `attack_sel`+1 when m > L and `decay_sel`+1 otherwise.
- R5: The target is k * 2^(SAMPLE_W-11). For `target_sel` codes 0 to 7, k is 544, 408, 324, 257, 204, 145, 102 and 65, from the loudest target to the quietest.
- R6: When a strobe finds L above the target, no step wait pending and a code above 0, the code falls by one. When L equals the target, the code holds.
- R7: When a strobe finds L below the target, L at or above `noise_thr`, no step wait pending and a code below `max_gain`, the code rises by one.
- R8: When a strobe finds L below `noise_thr`, the code is held.
- R9: A step down loads a wait of 2^`attack_sel`-1 strobes and a step up loads 2^`decay_sel`-1. While the wait is nonzero, each strobe decrements it and makes no step.
- R10: In loop mode, a code above `max_gain` is replaced by `max_gain` at the next clock edge. A step decision uses the clamped code.
- R11: The step decision of a strobe uses the level estimate held before that strobe's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle marker of a new ADC sample |
| sample_in | input | SAMPLE_W | Signed ADC sample |
| agc_en | input | 1 | 1: loop drives the gain; 0: fixed gain passes through |
| fixed_gain | input | GAIN_W | Gain code used when the loop is off |
| max_gain | input | GAIN_W | Ceiling for the loop's gain code |
| target_sel | input | SEL_W | Target level code (R5) |
| attack_sel | input | SEL_W | Attack shift and step interval setting |
| decay_sel | input | SEL_W | Decay shift and step interval setting |
| noise_thr | input | SAMPLE_W-1 | Level below which the gain is frozen |
| gain_code | output | GAIN_W | Requested gain in 0.5 dB units |
| gain_valid | output | 1 | Pulses after each sample update |

## Verification
The loop is driven with a quiet alternating tone that lets the code climb. It then gets a near-full-scale tone that forces it down, and a run of most-negative samples that exercises the magnitude saturation. Next comes silence that lets the estimate decay through the noise floor, and finally a mid-level tone against the quietest target. The climb and fall phases separate the attack and decay paths, including their wait counts. Silence tells a held code apart from one still rising. The first loud strobe after quiet material shows whether the decision reads the estimate before or after its update. Separate checks cover fixed-mode pass-through and a lowered ceiling that catches the code above its new limit.

// File: rtl/agc_pkg.sv
// Package: shared constants, types and the target-level decode for the
// absolute-average gain loop. Assumes target fractions are in 1/1024 of
// full-scale magnitude.
package agc_pkg;

    localparam int TGT_FRAC_W = 10;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_e;

    // Fraction of full scale (x1024) for each target code, loud to quiet.
    function automatic logic [TGT_FRAC_W-1:0] target_frac(input logic [2:0] code);
        logic [TGT_FRAC_W-1:0] k;
        case (code)
            3'd0:    k = 10'd544;
            3'd1:    k = 10'd408;
            3'd2:    k = 10'd324;
            3'd3:    k = 10'd257;
            3'd4:    k = 10'd204;
            3'd5:    k = 10'd145;
            3'd6:    k = 10'd102;
            default: k = 10'd65;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/agc_level_meter.sv
// Level meter: forms the saturated magnitude of each strobed sample and runs
// a first-order recursive average on it. The shift comes from the attack
// setting when the magnitude exceeds the estimate, else from the decay
// setting. Assumes sample_stb is one cycle wide per sample.
module agc_level_meter #(
    parameter int SAMPLE_W = 16,
    parameter int SEL_W    = 3,
    localparam int AVG_W   = SAMPLE_W - 1,
    localparam int DIFF_W  = AVG_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_stb,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic [SEL_W-1:0]           attack_sel,
    input  logic [SEL_W-1:0]           decay_sel,
    output logic [AVG_W-1:0]           level
);

    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [AVG_W-1:0]    MAG_MAX  = {AVG_W{1'b1}};

    logic [SAMPLE_W-1:0]      negated;
    logic [AVG_W-1:0]         mag;
    logic                     rising;
    logic [SEL_W:0]           shamt;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] step;
    logic signed [DIFF_W-1:0] sum;
    logic [AVG_W-1:0]         level_q;

    // Saturated magnitude of the incoming sample.
    always_comb begin
        negated = ~sample_in + SAMPLE_W'(1);
        if (sample_in == MOST_NEG)
            mag = MAG_MAX;
        else if (sample_in[SAMPLE_W-1])
            mag = negated[AVG_W-1:0];
        else
            mag = sample_in[AVG_W-1:0];
    end

    // Direction-dependent shift and next estimate.
    always_comb begin
        rising = (mag > level_q);
        shamt  = rising ? ({1'b0, attack_sel} + 1'b1) : ({1'b0, decay_sel} + 1'b1);
        diff   = $signed({1'b0, mag}) - $signed({1'b0, level_q});
        step   = diff >>> shamt;
        sum    = $signed({1'b0, level_q}) + step;
    end

    // Estimate register, updated once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (sample_stb)
            level_q <= sum[AVG_W-1:0];
    end

    assign level = level_q;

endmodule

// File: rtl/agc_target_decode.sv
// Target decode: scales the coded target fraction to the width of the level
// estimate. The sample width picks left or right alignment. Purely
// combinational.
module agc_target_decode #(
    parameter int SAMPLE_W = 16,
    parameter int SEL_W    = 3,
    localparam int AVG_W   = SAMPLE_W - 1
) (
    input  logic [SEL_W-1:0] target_sel,
    output logic [AVG_W-1:0] target
);
    import agc_pkg::*;

    logic [2:0]            code;
    logic [TGT_FRAC_W-1:0] frac;

    // Reduce the select to the eight defined codes.
    always_comb begin
        code = 3'(target_sel);
        frac = target_frac(code);
    end

    generate
        if (AVG_W >= TGT_FRAC_W) begin : g_left
            localparam int LSH = AVG_W - TGT_FRAC_W;
            logic [AVG_W-1:0] wide;
            // Widen the fraction, then align it to full scale.
            always_comb begin
                wide   = AVG_W'(frac);
                target = wide << LSH;
            end
        end else begin : g_right
            localparam int RSH = TGT_FRAC_W - AVG_W;
            logic [TGT_FRAC_W-1:0] narrow;
            // Drop the fraction bits that the estimate cannot hold.
            always_comb begin
                narrow = frac >> RSH;
                target = narrow[AVG_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/agc_gain_stepper.sv
// Gain stepper: holds the loop's gain code and step wait counter. On each
// strobe it compares the pre-update level with the target and the noise
// floor, then moves the code by at most one step. Assumes level and target
// share one scale. The ceiling clamp applies on every cycle in loop mode.
module agc_gain_stepper #(
    parameter int AVG_W  = 15,
    parameter int GAIN_W = 7,
    parameter int SEL_W  = 3,
    localparam int CNT_W = (1 << SEL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              agc_en,
    input  logic [GAIN_W-1:0] fixed_gain,
    input  logic [GAIN_W-1:0] max_gain,
    input  logic [AVG_W-1:0]  level,
    input  logic [AVG_W-1:0]  target,
    input  logic [AVG_W-1:0]  noise_thr,
    input  logic [SEL_W-1:0]  attack_sel,
    input  logic [SEL_W-1:0]  decay_sel,
    output logic [GAIN_W-1:0] gain
);
    import agc_pkg::*;

    logic [GAIN_W-1:0] gain_q;
    logic [GAIN_W-1:0] g_eff;
    logic [CNT_W-1:0]  wait_q;
    logic [CNT_W-1:0]  wait_dn;
    logic [CNT_W-1:0]  wait_up;
    logic              busy;
    step_e             dir;

    // Clamp the held code to the ceiling and pick a step direction.
    always_comb begin
        g_eff   = (gain_q > max_gain) ? max_gain : gain_q;
        busy    = (wait_q != '0);
        wait_dn = (CNT_W'(1) << attack_sel) - CNT_W'(1);
        wait_up = (CNT_W'(1) << decay_sel) - CNT_W'(1);
        if (level > target && g_eff != '0)
            dir = STEP_DOWN;
        else if (level < target && level >= noise_thr && g_eff < max_gain)
            dir = STEP_UP;
        else
            dir = STEP_HOLD;
    end

    // Gain code and wait counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '0;
            wait_q <= '0;
        end else if (!agc_en) begin
            gain_q <= fixed_gain;
            wait_q <= '0;
        end else if (sample_stb && busy) begin
            gain_q <= g_eff;
            wait_q <= wait_q - CNT_W'(1);
        end else if (sample_stb) begin
            case (dir)
                STEP_DOWN: begin
                    gain_q <= g_eff - GAIN_W'(1);
                    wait_q <= wait_dn;
                end
                STEP_UP: begin
                    gain_q <= g_eff + GAIN_W'(1);
                    wait_q <= wait_up;
                end
                default: gain_q <= g_eff;
            endcase
        end else begin
            gain_q <= g_eff;
        end
    end

    assign gain = gain_q;

endmodule

// File: rtl/agc_absavg.sv
// Top of the absolute-average gain loop. It wires the level meter, target
// decode and gain stepper, and chooses between the loop's code and the fixed
// code. gain_valid is the strobe delayed by one register. Assumes one
// strobe per ADC sample and a synchronous active-low reset.
module agc_absavg #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 7,
    parameter int SEL_W    = 3,
    localparam int AVG_W   = SAMPLE_W - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_stb,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic                       agc_en,
    input  logic [GAIN_W-1:0]          fixed_gain,
    input  logic [GAIN_W-1:0]          max_gain,
    input  logic [SEL_W-1:0]           target_sel,
    input  logic [SEL_W-1:0]           attack_sel,
    input  logic [SEL_W-1:0]           decay_sel,
    input  logic [AVG_W-1:0]           noise_thr,
    output logic [GAIN_W-1:0]          gain_code,
    output logic                       gain_valid
);

    logic [AVG_W-1:0]  level_q;
    logic [AVG_W-1:0]  target_lvl;
    logic [GAIN_W-1:0] loop_gain;
    logic              valid_q;

    agc_level_meter #(.SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .sample_in  (sample_in),
        .attack_sel (attack_sel),
        .decay_sel  (decay_sel),
        .level      (level_q)
    );

    agc_target_decode #(.SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W)) u_target (
        .target_sel (target_sel),
        .target     (target_lvl)
    );

    agc_gain_stepper #(.AVG_W(AVG_W), .GAIN_W(GAIN_W), .SEL_W(SEL_W)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .agc_en     (agc_en),
        .fixed_gain (fixed_gain),
        .max_gain   (max_gain),
        .level      (level_q),
        .target     (target_lvl),
        .noise_thr  (noise_thr),
        .attack_sel (attack_sel),
        .decay_sel  (decay_sel),
        .gain       (loop_gain)
    );

    // Update marker: one cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= sample_stb;
    end

    assign gain_code  = agc_en ? loop_gain : fixed_gain;
    assign gain_valid = valid_q;

endmodule

// File: rtl/agc_absavg_sva.sv
// Checker for agc_absavg: watches the ports and the level estimate over time.
// It is bound into every instance of the top module.
module agc_absavg_sva #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 7,
    localparam int AVG_W   = SAMPLE_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_stb,
    input logic              agc_en,
    input logic [GAIN_W-1:0] max_gain,
    input logic [AVG_W-1:0]  noise_thr,
    input logic [AVG_W-1:0]  level,
    input logic [GAIN_W-1:0] gain_code,
    input logic              gain_valid
);

    assert_valid_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sample_stb)) |-> gain_valid);

    assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sample_stb)) |-> !gain_valid);

    assert_still_without_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && agc_en && $past(agc_en) && !$past(sample_stb)
         && ($past(gain_code) <= $past(max_gain))) |-> $stable(gain_code));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && agc_en && $past(agc_en) && ($past(gain_code) <= $past(max_gain)))
        |-> ((int'(gain_code) <= int'($past(gain_code)) + 1)
             && (int'($past(gain_code)) <= int'(gain_code) + 1)));

    assert_noise_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && agc_en && $past(agc_en) && $past(sample_stb)
         && ($past(level) < $past(noise_thr)) && ($past(gain_code) <= $past(max_gain)))
        |-> $stable(gain_code));

    assert_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && agc_en && $past(agc_en) && $stable(max_gain))
        |-> (gain_code <= max_gain));

endmodule

bind agc_absavg agc_absavg_sva #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .agc_en     (agc_en),
    .max_gain   (max_gain),
    .noise_thr  (noise_thr),
    .level      (level_q),
    .gain_code  (gain_code),
    .gain_valid (gain_valid)
);

// File: tb/agc_absavg_tb.sv
// Scoreboard bench: the driver models each strobe and queues the expected
// gain; the monitor pops and compares on every gain_valid pulse.
module agc_absavg_tb;

    localparam int SAMPLE_W = 16;
    localparam int GAIN_W   = 7;
    localparam int SEL_W    = 3;
    localparam int AVG_W    = SAMPLE_W - 1;

    typedef struct {
        int    gain;
        string tag;
    } exp_t;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       sample_stb = 1'b0;
    logic signed [SAMPLE_W-1:0] sample_in = '0;
    logic                       agc_en = 1'b1;
    logic [GAIN_W-1:0]          fixed_gain = '0;
    logic [GAIN_W-1:0]          max_gain = 7'd100;
    logic [SEL_W-1:0]           target_sel = '0;
    logic [SEL_W-1:0]           attack_sel = '0;
    logic [SEL_W-1:0]           decay_sel = '0;
    logic [AVG_W-1:0]           noise_thr = '0;
    logic [GAIN_W-1:0]          gain_code;
    logic                       gain_valid;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t sb[$];

    int m_avg = 0;
    int m_gain = 0;
    int m_cnt = 0;

    agc_absavg #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .SEL_W(SEL_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .sample_in  (sample_in),
        .agc_en     (agc_en),
        .fixed_gain (fixed_gain),
        .max_gain   (max_gain),
        .target_sel (target_sel),
        .attack_sel (attack_sel),
        .decay_sel  (decay_sel),
        .noise_thr  (noise_thr),
        .gain_code  (gain_code),
        .gain_valid (gain_valid)
    );

    always #10 clk = ~clk;

    function automatic int tgt_of(input int code);
        int k;
        case (code)
            0: k = 544; 1: k = 408; 2: k = 324; 3: k = 257;
            4: k = 204; 5: k = 145; 6: k = 102; default: k = 65;
        endcase
        return k * (1 << (SAMPLE_W - 11));
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of one strobe (R4..R11).
    task automatic model_strobe(input int x);
        int mag, diff, sh, g, tgt;
        mag = (x < 0) ? ((x == -(1 << (SAMPLE_W-1))) ? (1 << (SAMPLE_W-1)) - 1 : -x) : x;
        if (agc_en) begin
            g   = (m_gain > int'(max_gain)) ? int'(max_gain) : m_gain;
            tgt = tgt_of(int'(target_sel));
            if (m_cnt != 0) begin
                m_cnt--;
            end else if (m_avg > tgt && g > 0) begin
                g--; m_cnt = (1 << attack_sel) - 1;
            end else if (m_avg < tgt && m_avg >= int'(noise_thr) && g < int'(max_gain)) begin
                g++; m_cnt = (1 << decay_sel) - 1;
            end
            m_gain = g;
        end else begin
            m_gain = int'(fixed_gain);
            m_cnt  = 0;
        end
        diff  = mag - m_avg;
        sh    = (mag > m_avg) ? int'(attack_sel) + 1 : int'(decay_sel) + 1;
        m_avg = m_avg + (diff >>> sh);
    endtask

    task automatic strobe(input int x, input string tag);
        exp_t e;
        @(negedge clk);
        sample_in  = SAMPLE_W'(x);
        sample_stb = 1'b1;
        model_strobe(x);
        e.gain = agc_en ? m_gain : int'(fixed_gain);
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    // Monitor: compare every update pulse with the queued expectation (R2).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && gain_valid) begin
                if (sb.size() == 0) begin
                    check(1, 0, "R2 unexpected gain_valid");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(gain_code), e.gain, e.tag);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with the loop on.
        check(int'(gain_code), 0, "R1 gain after reset");
        check(int'(gain_valid), 0, "R1 valid after reset");

        // R3: fixed pass-through, combinational.
        agc_en = 1'b0; fixed_gain = 7'd37;
        #1 check(int'(gain_code), 37, "R3 fixed passthrough");
        for (int i = 0; i < 3; i++) strobe((i % 2) ? 1000 : -1000, "R3 fixed strobe");
        fixed_gain = 7'd12;
        #1 check(int'(gain_code), 12, "R3 fixed change");
        @(negedge clk);
        check(int'(gain_valid), 0, "R2 idle no valid");

        // R7: loop climbs on a quiet tone from the fixed start value.
        fixed_gain = 7'd20; max_gain = 7'd60;
        @(negedge clk);
        agc_en = 1'b1; m_gain = 20; m_cnt = 0;
        for (int i = 0; i < 10; i++) strobe((i % 2) ? 200 : -200, "R7 climb");

        // R9: decay wait of 3 strobes between rises.
        decay_sel = 3'd2;
        for (int i = 0; i < 12; i++) strobe((i % 2) ? 200 : -200, "R9 decay wait");

        // R11 then R6: first loud strobe decides on the quiet estimate.
        attack_sel = 3'd1; decay_sel = 3'd0;
        strobe(30000, "R11 pre-update level");
        for (int i = 0; i < 20; i++) strobe((i % 2) ? 30000 : -30000, "R6 attack fall");

        // R4: most negative input saturates.
        for (int i = 0; i < 10; i++) strobe(-32768, "R4 saturation");

        // R8: silence decays through the noise floor, then the code holds.
        noise_thr = 15'd2000;
        for (int i = 0; i < 24; i++) strobe(0, "R8 noise hold");

        // R5: quietest target with a mid-level tone.
        noise_thr = '0; target_sel = 3'd7;
        for (int i = 0; i < 30; i++) strobe((i % 2) ? 2500 : -2500, "R5 target code 7");
        target_sel = 3'd3;
        for (int i = 0; i < 16; i++) strobe((i % 2) ? 12000 : -12000, "R5 target code 3");

        // R10: lowering the ceiling clamps at the next edge.
        @(negedge clk);
        max_gain = 7'd5;
        if (m_gain > 5) m_gain = 5;
        @(negedge clk);
        check(int'(gain_code), m_gain, "R10 ceiling clamp");
        for (int i = 0; i < 6; i++) strobe((i % 2) ? 100 : -100, "R10 held at ceiling");

        repeat (3) @(negedge clk);
        check(sb.size(), 0, "R2 every strobe answered");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule